// File: doc/BRIEF.md
# User-Port Protection Checker

This block sits on the receive side of a node's communication assist and guards the entry to user space. Every arriving message envelope carries a user/system flag and a small tag. The tag selects an entry of a local mapping table. The entry holds a valid bit and a context identifier. A user message whose entry is valid and names the context now running is written into that network's user-visible receive FIFO. The running program can then drain it directly, with no operating-system code on the path.

All other traffic is diverted to a per-network system FIFO, and that network's interrupt line is raised. This covers messages flagged as system traffic and user messages whose entry is invalid or belongs to another context. Two independent data networks are served. Each has its own user FIFO, system FIFO and interrupt. The two networks share the single table read port through a fair round-robin turn. Table management software writes entries through a plain write port, and a separate input carries the current context.

Top module: `port_guard`

## Requirements
- R1: A user message (`in_sys` = 0) whose tag entry is valid and whose stored context equals `cur_ctx` is written to the user FIFO of its own network. It is visible on `usr_valid`/`usr_data` in the cycle after the clock edge that accepted it. Messages leave that FIFO in arrival order.
- R2: A message with `in_sys` = 1 goes to the system FIFO of its network, whatever its table entry holds.
- R3: A user message whose tag selects an entry with the valid bit clear goes to the system FIFO.
- R4: A user message whose entry is valid but whose stored context differs from `cur_ctx` goes to the system FIFO. The comparison uses the value `cur_ctx` has in the accepting cycle.
- R5: `irq[i]` is high exactly while system FIFO `i` holds at least one message. It rises in the cycle after the first system write and falls in the cycle after the last pop.
- R6: The networks are independent. A message arriving on network `i` appears only on network `i`'s outputs.
- R7: At most one table lookup happens per cycle, so at most one `in_ready` bit is high. When both networks keep `in_valid` high, the turn alternates every cycle.
- R8: A message whose target FIFO is full is not accepted and stays at the input. The other network still gets its turn in the following cycle.
- R9: After reset every table entry is invalid. A table write through `tbl_we` takes effect for lookups from the next cycle on.
- R10: After reset all FIFOs are empty, `irq` is low and `in_ready` is low while no `in_valid` is high.
- R11: A pop on an empty FIFO is ignored. The FIFO stays empty, and a later message is returned intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_ctx | input | CTX_W | Identifier of the running user context |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | TAG_W | Table entry to write |
| tbl_valid | input | 1 | Valid bit to store |
| tbl_ctx | input | CTX_W | Context identifier to store |
| in_valid | input | NUM_NETS | Message offered, one bit per network |
| in_sys | input | NUM_NETS | Envelope user/system flag (1 = system) |
| in_tag | input | NUM_NETS*TAG_W | Envelope tags, network i at bits i*TAG_W |
| in_data | input | NUM_NETS*DATA_W | Message payloads, network i at bits i*DATA_W |
| in_ready | output | NUM_NETS | Message taken at this clock edge |
| usr_valid | output | NUM_NETS | User FIFO non-empty |
| usr_data | output | NUM_NETS*DATA_W | Head of each user FIFO |
| usr_pop | input | NUM_NETS | Remove head of user FIFO |
| sys_valid | output | NUM_NETS | System FIFO non-empty |
| sys_data | output | NUM_NETS*DATA_W | Head of each system FIFO |
| sys_pop | input | NUM_NETS | Remove head of system FIFO |
| irq | output | NUM_NETS | Level interrupt per network |

## Verification
The bench targets each way a user message can be refused: an invalid entry, a stale context that becomes valid once `cur_ctx` changes, and an entry cleared by a later write. A design that checked only the flag, cached the context or read the table one cycle late would put such messages into user space. Both networks are held valid together to show the turn alternating. A full user FIFO is used to show that the blocked network neither loses its message nor starves its neighbour; a wrong design would drop the message, overwrite the FIFO or stall both networks. Popping an empty FIFO and then checking a fresh message catches pointer corruption. Watching `irq` as the system FIFO drains catches an interrupt that is edge-like or sticky.

// File: rtl/guard_pkg.sv
package guard_pkg;
  typedef enum logic {
    ROUTE_USER = 1'b0,
    ROUTE_SYS  = 1'b1
  } route_e;
endpackage

// File: rtl/guard_fifo.sv
module guard_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic         nonempty,
  output logic [W-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full     = (cnt_q == CW'(DEPTH));
  assign nonempty = (cnt_q != '0);
  assign dout     = mem[rd_q];
  assign do_push  = push && !full;
  assign do_pop   = pop && nonempty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  // R8: the parent must never write a full FIFO
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R11: popping an empty FIFO leaves it empty
  a_r11_empty_pop_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !nonempty && !push) |=> !nonempty);
endmodule

// File: rtl/guard_map_table.sv
module guard_map_table #(
  parameter int TAG_W = 3,
  parameter int CTX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [TAG_W-1:0] waddr,
  input  logic             wvalid,
  input  logic [CTX_W-1:0] wctx,
  input  logic [TAG_W-1:0] raddr,
  output logic             rvalid,
  output logic [CTX_W-1:0] rctx
);
  localparam int ENTRIES = 1 << TAG_W;

  logic [ENTRIES-1:0] ent_v_q;
  logic [ENTRIES-1:0] ent_v_d;
  logic [CTX_W-1:0]   ent_ctx [ENTRIES];

  assign rvalid = ent_v_q[raddr];
  assign rctx   = ent_ctx[raddr];

  always_comb begin
    ent_v_d = ent_v_q;
    if (we) ent_v_d[waddr] = wvalid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_v_q <= '0;
    else        ent_v_q <= ent_v_d;
  end

  always_ff @(posedge clk) begin
    if (we) ent_ctx[waddr] <= wctx;
  end

  // R9: a written entry is seen from the next cycle
  a_r9_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ent_v_q[$past(waddr)] == $past(wvalid)));
endmodule

// File: rtl/guard_rr_arb.sv
module guard_rr_arb #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q, ptr_d, gidx;
  logic          found;
  int            t;

  always_comb begin
    gnt   = '0;
    gidx  = '0;
    found = 1'b0;
    t     = 0;
    for (int k = 0; k < N; k++) begin
      t = int'(ptr_q) + k;
      if (t >= N) t = t - N;
      if (!found && req[t]) begin
        gnt[t] = 1'b1;
        gidx   = IW'(t);
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (found) ptr_d = (gidx == IW'(N - 1)) ? '0 : gidx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // last winner, kept for the fairness check only
  logic [N-1:0] last_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_q <= '0;
    else if (found) last_q <= gnt;
  end

  // R7: one lookup per cycle
  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R7: the previous winner yields when another network is waiting
  a_r7_turn_passes: assert property (@(posedge clk) disable iff (!rst_n)
    ((|last_q) && (|(req & ~last_q))) |-> ((gnt & last_q) == '0));
endmodule

// File: rtl/port_guard.sv
module port_guard
  import guard_pkg::*;
#(
  parameter int NUM_NETS = 2,
  parameter int TAG_W    = 3,
  parameter int CTX_W    = 4,
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CTX_W-1:0]           cur_ctx,
  input  logic                       tbl_we,
  input  logic [TAG_W-1:0]           tbl_addr,
  input  logic                       tbl_valid,
  input  logic [CTX_W-1:0]           tbl_ctx,
  input  logic [NUM_NETS-1:0]        in_valid,
  input  logic [NUM_NETS-1:0]        in_sys,
  input  logic [NUM_NETS*TAG_W-1:0]  in_tag,
  input  logic [NUM_NETS*DATA_W-1:0] in_data,
  output logic [NUM_NETS-1:0]        in_ready,
  output logic [NUM_NETS-1:0]        usr_valid,
  output logic [NUM_NETS*DATA_W-1:0] usr_data,
  input  logic [NUM_NETS-1:0]        usr_pop,
  output logic [NUM_NETS-1:0]        sys_valid,
  output logic [NUM_NETS*DATA_W-1:0] sys_data,
  input  logic [NUM_NETS-1:0]        sys_pop,
  output logic [NUM_NETS-1:0]        irq
);
  logic [NUM_NETS-1:0] gnt;
  logic [TAG_W-1:0]    sel_tag;
  logic                sel_sys;
  logic                ent_valid;
  logic [CTX_W-1:0]    ent_ctx;
  route_e              route;
  logic [NUM_NETS-1:0] usr_full, sys_full, usr_push, sys_push;

  guard_rr_arb #(.N(NUM_NETS)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(in_valid), .gnt(gnt)
  );

  // select the envelope of the network holding the turn
  always_comb begin
    sel_tag = '0;
    sel_sys = 1'b0;
    for (int i = 0; i < NUM_NETS; i++) begin
      if (gnt[i]) begin
        sel_tag = sel_tag | in_tag[i*TAG_W +: TAG_W];
        sel_sys = sel_sys | in_sys[i];
      end
    end
  end

  guard_map_table #(.TAG_W(TAG_W), .CTX_W(CTX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .we(tbl_we), .waddr(tbl_addr), .wvalid(tbl_valid), .wctx(tbl_ctx),
    .raddr(sel_tag), .rvalid(ent_valid), .rctx(ent_ctx)
  );

  always_comb begin
    if (!sel_sys && ent_valid && (ent_ctx == cur_ctx)) route = ROUTE_USER;
    else                                               route = ROUTE_SYS;
  end

  for (genvar g = 0; g < NUM_NETS; g++) begin : g_net
    assign usr_push[g] = gnt[g] && (route == ROUTE_USER) && !usr_full[g];
    assign sys_push[g] = gnt[g] && (route == ROUTE_SYS)  && !sys_full[g];
    assign in_ready[g] = usr_push[g] || sys_push[g];

    guard_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_usr_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(usr_push[g]), .din(in_data[g*DATA_W +: DATA_W]), .full(usr_full[g]),
      .pop(usr_pop[g]), .nonempty(usr_valid[g]), .dout(usr_data[g*DATA_W +: DATA_W])
    );

    guard_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_sys_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(sys_push[g]), .din(in_data[g*DATA_W +: DATA_W]), .full(sys_full[g]),
      .pop(sys_pop[g]), .nonempty(sys_valid[g]), .dout(sys_data[g*DATA_W +: DATA_W])
    );

    assign irq[g] = sys_valid[g];

    // R5: the interrupt only comes up after a diverted message was stored
    a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[g]) |-> $past(sys_push[g]));
    // R7: a network is only told ready while it offers a message
    a_r7_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready[g] |-> in_valid[g]);
  end

  // R7: at most one network advances per cycle
  a_r7_one_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));
endmodule

// File: tb/port_guard_bench.sv
`timescale 1ns/1ps
module port_guard_bench;
  localparam int NN = 2, TW = 3, CW = 4, DW = 16, DEP = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [CW-1:0]    cur_ctx;
  logic             tbl_we, tbl_valid;
  logic [TW-1:0]    tbl_addr;
  logic [CW-1:0]    tbl_ctx;
  logic [NN-1:0]    in_valid, in_sys, in_ready;
  logic [NN*TW-1:0] in_tag;
  logic [NN*DW-1:0] in_data;
  logic [NN-1:0]    usr_valid, usr_pop, sys_valid, sys_pop, irq;
  logic [NN*DW-1:0] usr_data, sys_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  port_guard #(.NUM_NETS(NN), .TAG_W(TW), .CTX_W(CW), .DATA_W(DW), .DEPTH(DEP)) u_port_guard (
    .clk(clk), .rst_n(rst_n), .cur_ctx(cur_ctx),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_valid(tbl_valid), .tbl_ctx(tbl_ctx),
    .in_valid(in_valid), .in_sys(in_sys), .in_tag(in_tag), .in_data(in_data),
    .in_ready(in_ready), .usr_valid(usr_valid), .usr_data(usr_data), .usr_pop(usr_pop),
    .sys_valid(sys_valid), .sys_data(sys_data), .sys_pop(sys_pop), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr_tbl(logic [TW-1:0] a, logic v, logic [CW-1:0] c);
    tbl_we = 1; tbl_addr = a; tbl_valid = v; tbl_ctx = c;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic send(int n, logic s, logic [TW-1:0] t, logic [DW-1:0] d);
    bit acc = 0;
    in_valid[n] = 1; in_sys[n] = s; in_tag[n*TW +: TW] = t; in_data[n*DW +: DW] = d;
    for (int w = 0; w < 20 && !acc; w++) begin
      #1 acc = in_ready[n];
      @(negedge clk);
    end
    in_valid[n] = 0;
    chk("R1 accept", 32'(acc), 32'd1);
  endtask

  task automatic take(string req, int n, bit from_sys, logic [DW-1:0] exp);
    if (from_sys) begin
      chk(req, 32'(sys_valid[n]), 32'd1);
      chk(req, 32'(sys_data[n*DW +: DW]), 32'(exp));
      sys_pop[n] = 1;
    end else begin
      chk(req, 32'(usr_valid[n]), 32'd1);
      chk(req, 32'(usr_data[n*DW +: DW]), 32'(exp));
      usr_pop[n] = 1;
    end
    @(negedge clk);
    sys_pop[n] = 0; usr_pop[n] = 0;
  endtask

  task automatic t_reset();
    chk("R10 usr_valid", 32'(usr_valid), 32'd0);
    chk("R10 sys_valid", 32'(sys_valid), 32'd0);
    chk("R10 irq", 32'(irq), 32'd0);
    chk("R10 in_ready", 32'(in_ready), 32'd0);
  endtask

  task automatic t_user_path();
    send(0, 0, 3'd1, 16'hA001);
    chk("R1 usr_valid next cycle", 32'(usr_valid), 32'b01);
    chk("R6 net1 untouched", 32'(usr_valid[1] | sys_valid[1]), 32'd0);
    chk("R1 no irq", 32'(irq), 32'd0);
    take("R1 data", 0, 0, 16'hA001);
    send(1, 0, 3'd1, 16'hA101);
    chk("R6 net0 untouched", 32'(usr_valid[0] | sys_valid[0]), 32'd0);
    take("R6 net1 data", 1, 0, 16'hA101);
  endtask

  task automatic t_sys_flag();
    send(1, 1, 3'd1, 16'hB001);
    chk("R2 sys routed", 32'(sys_valid), 32'b10);
    chk("R2 not in user", 32'(usr_valid), 32'd0);
    chk("R5 irq raised", 32'(irq), 32'b10);
    send(1, 1, 3'd2, 16'hB002);
    take("R2 first", 1, 1, 16'hB001);
    chk("R5 irq held while non-empty", 32'(irq), 32'b10);
    take("R2 second", 1, 1, 16'hB002);
    chk("R5 irq dropped", 32'(irq), 32'd0);
  endtask

  task automatic t_invalid_entry();
    send(0, 0, 3'd3, 16'hC003);
    chk("R3 invalid entry diverted", 32'(usr_valid), 32'd0);
    chk("R3 irq", 32'(irq), 32'b01);
    take("R3 data", 0, 1, 16'hC003);
  endtask

  task automatic t_ctx_mismatch();
    send(0, 0, 3'd2, 16'hD002);
    chk("R4 mismatch diverted", 32'(usr_valid), 32'd0);
    take("R4 data", 0, 1, 16'hD002);
    cur_ctx = 4'd3;
    send(0, 0, 3'd2, 16'hD102);
    chk("R4 matches after switch", 32'(usr_valid), 32'b01);
    chk("R4 no irq", 32'(irq), 32'd0);
    take("R4 user data", 0, 0, 16'hD102);
    send(0, 0, 3'd1, 16'hD201);
    chk("R4 old context now diverted", 32'(sys_valid), 32'b01);
    take("R4 diverted data", 0, 1, 16'hD201);
    cur_ctx = 4'd5;
  endtask

  task automatic t_table_write();
    wr_tbl(3'd1, 1'b0, 4'd5);
    send(1, 0, 3'd1, 16'hE001);
    chk("R9 cleared entry diverts", 32'(sys_valid), 32'b10);
    take("R9 data", 1, 1, 16'hE001);
    wr_tbl(3'd1, 1'b1, 4'd5);
    send(1, 0, 3'd1, 16'hE002);
    chk("R9 restored entry delivers", 32'(usr_valid), 32'b10);
    take("R9 user data", 1, 0, 16'hE002);
  endtask

  task automatic t_arbitration();
    logic [NN-1:0] first;
    in_valid = 2'b11; in_sys = 2'b00; in_tag = {3'd1, 3'd1};
    in_data = {16'hF100, 16'hF000};
    #1 first = in_ready;
    chk("R7 one ready", 32'($countones(first)), 32'd1);
    @(negedge clk);
    #1 chk("R7 turn alternates", 32'(in_ready), 32'(~first & 2'b11));
    @(negedge clk);
    in_valid = 2'b00;
    take("R7 net0 delivered", 0, 0, 16'hF000);
    take("R7 net1 delivered", 1, 0, 16'hF100);
  endtask

  task automatic t_backpressure();
    bit n1_acc = 0;
    for (int k = 0; k < DEP; k++) send(0, 0, 3'd1, 16'h0100 + 16'(k));
    in_valid = 2'b11; in_sys = 2'b00; in_tag = {3'd1, 3'd1};
    in_data = {16'h0200, 16'h0104};
    for (int c = 0; c < 2; c++) begin
      #1;
      chk("R8 full network held", 32'(in_ready[0]), 32'd0);
      if (in_ready[1]) n1_acc = 1;
      @(negedge clk);
      if (n1_acc) in_valid[1] = 0;
    end
    chk("R8 other network served", 32'(n1_acc), 32'd1);
    #1 chk("R8 still held", 32'(in_ready[0]), 32'd0);
    take("R8 head", 0, 0, 16'h0100);
    #1 chk("R8 accepted once room", 32'(in_ready[0]), 32'd1);
    @(negedge clk);
    in_valid = 2'b00;
    for (int k = 1; k <= DEP; k++) take("R1 order", 0, 0, 16'h0100 + 16'(k));
    chk("R1 drained", 32'(usr_valid[0]), 32'd0);
    take("R8 net1 data", 1, 0, 16'h0200);
  endtask

  task automatic t_empty_pop();
    usr_pop = 2'b11; sys_pop = 2'b11;
    @(negedge clk);
    usr_pop = 2'b00; sys_pop = 2'b00;
    chk("R11 still empty", 32'({usr_valid, sys_valid}), 32'd0);
    chk("R11 no irq", 32'(irq), 32'd0);
    send(1, 0, 3'd1, 16'h5A5A);
    take("R11 intact after empty pop", 1, 0, 16'h5A5A);
    chk("R11 empty again", 32'(usr_valid), 32'd0);
  endtask

  initial begin
    rst_n = 0; cur_ctx = 4'd5;
    tbl_we = 0; tbl_addr = '0; tbl_valid = 0; tbl_ctx = '0;
    in_valid = '0; in_sys = '0; in_tag = '0; in_data = '0;
    usr_pop = '0; sys_pop = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    wr_tbl(3'd1, 1'b1, 4'd5);
    wr_tbl(3'd2, 1'b1, 4'd3);
    t_user_path();
    t_sys_flag();
    t_invalid_entry();
    t_ctx_mismatch();
    t_table_write();
    t_arbitration();
    t_backpressure();
    t_empty_pop();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule